// File: doc/BRIEF.md
# Quadrature Burst Waveform Generator

This block emits a pair of square waves, phase A and phase B, a quarter period apart, for a programmed number of half-cycles, and then stops. A single period counter runs from zero up to the programmed half-period value and wraps. Each wrap toggles phase A. A second compare, at half of that value, toggles phase B.

The lead/lag sense is set by inverting phase B at the output. The compare points are never moved for this. A half-cycle counter advances on every phase-A toggle. When it has seen the programmed number, it removes the run enable from the period counter. After that, both outputs keep whatever levels they reached.

All controls are plain level or strobe pins. Nothing streams into or out of the block, so there is no valid/ready handshake. A burst is launched with a one-cycle `start` strobe while the block is idle. Software or a sequencer can then watch `busy` and `done`.

Top module: `quad_burst_gen`

## Requirements
- R1: After a `start` edge, the period counter runs through the values 0 up to H, where H is the latched half-period. One half-cycle therefore lasts H+1 clock cycles. Phase A toggles on every wrap, so its first toggle follows the launching edge by H+1 cycles.
- R2: Phase B, before any inversion, toggles when the counter equals H shifted right by one bit. Its first change follows the launching edge by (H>>1)+1 cycles.
- R3: Direction bit 0 makes B lead A. Direction bit 1 drives B through an inverter, which makes A lead B. The latched direction is applied to B from the cycle after the launching edge.
- R4: A half-period below 4 is raised to 4. A half-cycle count below 2 is raised to 2. Values up to 65535 are used as given.
- R5: A burst ends after exactly N phase-A toggles, where N is the latched count. It ends on the edge of the N-th toggle. The counters then stop, and both phase outputs hold their last levels while idle. As a result, an odd N leaves A at the opposite of its starting level.
- R6: `done` is high for exactly one cycle, the cycle that follows the final toggle edge. `busy` is low in that same cycle and was high in every cycle of the burst before it.
- R7: Half-period, count and direction are sampled only on an accepted `start`. Changing these inputs during a burst has no effect on that burst.
- R8: A `start` strobe that arrives while `busy` is high is ignored.
- R9: Reset drives phase A, phase B, `busy` and `done` low.
- R10: A half-period of 159 gives a full A period of 320 clock cycles. At a 32 MHz clock this is 100 kHz, or a 400 kHz combined edge rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_period | input | 16 | Half-period in clock cycles, minus one tick of wrap (H) |
| dir | input | 1 | 0: B leads A; 1: A leads B |
| half_count | input | 16 | Number of half-cycles (A toggles) per burst |
| start | input | 1 | One-cycle launch strobe, honoured only while idle |
| phase_a | output | 1 | Quadrature phase A |
| phase_b | output | 1 | Quadrature phase B, after direction inversion |
| busy | output | 1 | High while a burst is running |
| done | output | 1 | One-cycle pulse after the final half-cycle |

## Verification
The hardest situation to reach from the ports is a second launch attempt arriving mid-burst with different settings on every input. If the design mishandled it, the attempt would either restart the counters or swap the latched values, so only the timing and count of later edges would show the fault. The stimulus pulses `start` a few cycles into a burst, with new period, count and direction values held on the inputs. An independent cycle model, which tracks elapsed time since launch, must then still match every output edge. Clamped inputs are driven with illegal small values, and the resulting edge spacing is measured.

// File: rtl/qbg_pkg.sv
package qbg_pkg;
  typedef enum logic {
    DIR_B_LEADS = 1'b0,
    DIR_A_LEADS = 1'b1
  } qbg_dir_e;
endpackage

// File: rtl/qbg_cfg.sv
module qbg_cfg
  import qbg_pkg::*;
#(
  parameter int HW       = 16,
  parameter int LW       = 16,
  parameter int MIN_HALF = 4,
  parameter int MIN_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] half_in,
  input  logic [LW-1:0] len_in,
  input  logic          dir_in,
  output logic [HW-1:0] half_q,
  output logic [LW-1:0] len_q,
  output qbg_dir_e      dir_q
);
  localparam logic [HW-1:0] HALF_FLOOR = HW'(MIN_HALF);
  localparam logic [LW-1:0] LEN_FLOOR  = LW'(MIN_LEN);

  // settings are sampled only when a launch is accepted; illegal small values are raised
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_FLOOR;
      len_q  <= LEN_FLOOR;
      dir_q  <= DIR_B_LEADS;
    end else if (load) begin
      half_q <= (half_in < HALF_FLOOR) ? HALF_FLOOR : half_in;
      len_q  <= (len_in < LEN_FLOOR) ? LEN_FLOOR : len_in;
      dir_q  <= qbg_dir_e'(dir_in);
    end
  end

  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    half_q >= HALF_FLOOR); // R4
  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    len_q >= LEN_FLOOR); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(half_q) && $stable(len_q) && $stable(dir_q)); // R7
endmodule

// File: rtl/qbg_timebase.sv
module qbg_timebase #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [HW-1:0] half_q,
  output logic          wrap,
  output logic          ph_a,
  output logic          ph_b_raw
);
  logic [HW-1:0] cnt;
  logic [HW-1:0] mid;

  assign mid  = half_q >> 1;
  assign wrap = run && (cnt == half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ph_a     <= 1'b0;
      ph_b_raw <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == half_q) begin
        cnt  <= '0;
        ph_a <= ~ph_a;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cnt == mid) ph_b_raw <= ~ph_b_raw;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= half_q); // R1
  AST_A_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ph_a != $past(ph_a)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(ph_a) && $stable(ph_b_raw)); // R5
endmodule

// File: rtl/qbg_burst.sv
module qbg_burst #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          wrap,
  input  logic [LW-1:0] len_q,
  output logic          busy,
  output logic          done
);
  logic [LW-1:0] hc;
  logic          last;

  assign last = (hc == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        hc   <= '0;
        busy <= 1'b1;
      end else if (busy && wrap) begin
        if (last) begin
          hc   <= '0;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
  AST_HC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> hc < len_q); // R5
endmodule

// File: rtl/quad_burst_gen.sv
module quad_burst_gen
  import qbg_pkg::*;
#(
  parameter int HW       = 16,
  parameter int LW       = 16,
  parameter int MIN_HALF = 4,
  parameter int MIN_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_period,
  input  logic          dir,
  input  logic [LW-1:0] half_count,
  input  logic          start,
  output logic          phase_a,
  output logic          phase_b,
  output logic          busy,
  output logic          done
);
  logic          launch;
  logic          wrap;
  logic          ph_b_raw;
  logic [HW-1:0] half_q;
  logic [LW-1:0] len_q;
  qbg_dir_e      dir_q;

  assign launch  = start && !busy;
  assign phase_b = ph_b_raw ^ (dir_q == DIR_A_LEADS);

  qbg_cfg #(.HW(HW), .LW(LW), .MIN_HALF(MIN_HALF), .MIN_LEN(MIN_LEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .half_in(half_period), .len_in(half_count), .dir_in(dir),
    .half_q(half_q), .len_q(len_q), .dir_q(dir_q)
  );

  qbg_timebase #(.HW(HW)) u_tb (
    .clk(clk), .rst_n(rst_n), .restart(launch), .run(busy),
    .half_q(half_q), .wrap(wrap), .ph_a(phase_a), .ph_b_raw(ph_b_raw)
  );

  qbg_burst #(.LW(LW)) u_burst (
    .clk(clk), .rst_n(rst_n), .launch(launch), .wrap(wrap),
    .len_q(len_q), .busy(busy), .done(done)
  );

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(half_q) && $stable(dir_q)); // R8
endmodule

// File: tb/quad_burst_gen_bench.sv
`timescale 1ns/1ps
module quad_burst_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_period = 16'd9;
  logic        dir = 1'b0;
  logic [15:0] half_count = 16'd4;
  logic        start = 1'b0;
  logic        phase_a, phase_b, busy, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  quad_burst_gen u_quad_burst_gen (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .dir(dir),
    .half_count(half_count), .start(start), .phase_a(phase_a),
    .phase_b(phase_b), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: time elapsed since launch decides every edge
  bit m_busy = 0, m_done = 0, m_a = 0, m_braw = 0, m_dir = 0;
  int m_h = 4, m_len = 2, m_mid = 2, m_k = 0, m_na = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_a = 0; m_braw = 0; m_dir = 0; m_k = 0; m_na = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_k++;
        if ((m_k - m_mid - 1) % (m_h + 1) == 0) m_braw = ~m_braw;
        if (m_k % (m_h + 1) == 0) begin
          m_a = ~m_a;
          m_na++;
          if (m_na == m_len) begin m_busy = 0; m_done = 1; end
        end
      end else if (start) begin
        m_h   = (half_period < 4) ? 4 : int'(half_period);
        m_len = (half_count < 2) ? 2 : int'(half_count);
        m_mid = m_h / 2;
        m_dir = dir;
        m_k = 0; m_na = 0; m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(phase_a == m_a, "R1 phase_a vs model", phase_a, m_a);
      chk(phase_b == (m_braw ^ m_dir), "R2/R3 phase_b vs model", phase_b, m_braw ^ m_dir);
      chk(busy == m_busy, "R5 busy vs model", busy, m_busy);
      chk(done == m_done, "R6 done vs model", done, m_done);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic burst(input int h, input int n, input bit d, input bit disturb);
    int he, ne, cyc, ta, ta2, tb, na;
    bit pa, pb, a_before, b_first, hold_a, hold_b;
    he = (h < 4) ? 4 : h;
    ne = (n < 2) ? 2 : n;
    @(negedge clk);
    half_period = 16'(h); half_count = 16'(n); dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R5 busy after launch", busy, 1);
    cyc = 0; ta = 0; ta2 = 0; tb = 0; na = 0;
    a_before = phase_a; b_first = 1'b0;
    pa = phase_a; pb = phase_b;
    while (!done && cyc < 100000) begin
      if (disturb && cyc == 3) begin
        start = 1'b1; half_period = 16'(h + 7); half_count = 16'(n + 9); dir = ~d;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (phase_b != pb && tb == 0) begin tb = cyc; b_first = phase_b; end
      if (phase_a != pa) begin
        na++;
        if (ta == 0) ta = cyc; else if (ta2 == 0) ta2 = cyc;
      end
      pa = phase_a; pb = phase_b;
    end
    start = 1'b0;
    chk(ta == he + 1, "R1/R4 first A toggle delay", ta, he + 1);
    chk(ta2 == 2 * (he + 1), "R1/R10 second A toggle delay", ta2, 2 * (he + 1));
    chk(tb == he / 2 + 1, "R2 first B change delay", tb, he / 2 + 1);
    chk(b_first == (d ? a_before : ~a_before), "R3 lead/lag sense", b_first, d ? a_before : ~a_before);
    chk(na == ne, "R5/R7/R8 A toggle count", na, ne);
    chk(cyc == ne * (he + 1), "R6 done timing", cyc, ne * (he + 1));
    chk(busy == 1'b0, "R6 busy low with done", busy, 0);
    chk(phase_a == (a_before ^ ne[0]), "R5 ending A level", phase_a, a_before ^ ne[0]);
    hold_a = phase_a; hold_b = phase_b;
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    repeat (8) @(negedge clk);
    chk(phase_a == hold_a && phase_b == hold_b, "R5 outputs hold", {phase_a, phase_b}, {hold_a, hold_b});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(phase_a == 0 && phase_b == 0, "R9 reset phases", {phase_a, phase_b}, 0);
    chk(busy == 0 && done == 0, "R9 reset status", {busy, done}, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    burst(9, 4, 1'b0, 1'b0);
    burst(9, 4, 1'b1, 1'b0);
    burst(6, 3, 1'b0, 1'b0);
    burst(13, 5, 1'b0, 1'b0);
    burst(1, 0, 1'b1, 1'b0);
    burst(20, 5, 1'b0, 1'b1);
    burst(11, 6, 1'b1, 1'b1);
    burst(159, 4, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule